// File: doc/BRIEF.md
# Timer Preload Update Controller

This block decides the clock cycles in which the shadow copies of a PWM timer's period, compare and similar settings are moved into the registers the counter actually uses. It watches strobes from the timer's counter (reset, rollover, repetition count at zero), a software strobe, update strobes from a master timer and from sibling timers, a burst-DMA-complete strobe and three external update-enable lines. It turns them into a single-cycle transfer strobe. A request pulse for an interrupt or DMA channel follows each transfer by one cycle.

A 4-bit gate code selects the policy. Code 0 lets the normal sources through. With code 0, a resync flag can hold master, sibling and software updates until the next counter reset or rollover. Codes 1 to 8 either fire straight from DMA completion or an external edge, or arm a flag that the next normal update event consumes. Codes 9 to 15 block all hardware sources. The counter, prescaler and shadow registers are outside the block. The transfer strobe `xfer_o` goes high in the cycle after the clock edge that sampled the causing input.

Top module: `preload_xfer_ctrl`

## Requirements
- R1: A software strobe gives a transfer in the next cycle under every gate code, except code 0 with resync set. The same strobe clears the armed flag and any held update.
- R2: With code 0 and repetition updates enabled, a rollover while the repetition-zero flag is high gives a transfer. A rollover with that flag low gives none.
- R3: With code 0 and reset updates enabled, a counter reset gives a transfer. So does a rollover while the continuous-mode input is high.
- R4: Code 1 transfers on every DMA-complete strobe. Counter, master and sibling events alone give no transfer in this code.
- R5: Code 2 arms on a DMA-complete strobe. The next enabled normal event (repetition, reset, master or sibling) transfers and clears the flag. An event in the arming cycle itself does not fire.
- R6: Codes 3, 4 and 5 transfer on a rising edge of external line 0, 1 and 2 respectively. A line held high does not fire again, and other lines are ignored.
- R7: Codes 6, 7 and 8 arm on a rising edge of external line 0, 1 and 2 respectively. The following enabled normal event transfers.
- R8: Codes 9 to 15 never transfer from a hardware source. Only the software strobe transfers.
- R9: With code 0 and resync set, master, sibling and software updates are held and give no transfer until a counter reset or rollover. A transfer then follows.
- R10: The resync flag is ignored for every code other than 0, so master and sibling events act at once.
- R11: `req_o` is high exactly in the cycle after each `xfer_o` pulse and at no other time. Both are single-cycle.
- R12: While `rst_n` is low, `xfer_o` and `req_o` are 0 and the armed and held state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctr_reset_i | input | 1 | Counter reset strobe |
| ctr_roll_i | input | 1 | Counter rollover strobe |
| rep_zero_i | input | 1 | Repetition counter equals zero |
| continuous_i | input | 1 | Counter runs in continuous mode |
| sw_upd_i | input | 1 | Software update strobe |
| master_upd_i | input | 1 | Master timer update strobe |
| sib_upd_i | input | N_SIB | Sibling timer update strobes |
| dma_done_i | input | 1 | Burst DMA complete strobe |
| ext_en_i | input | N_EXT | External update-enable lines (edge sensitive) |
| cfg_rep_en_i | input | 1 | Enable repetition update |
| cfg_rst_en_i | input | 1 | Enable reset/rollover update |
| cfg_master_en_i | input | 1 | Enable master timer update |
| cfg_sib_en_i | input | N_SIB | Enable per sibling timer |
| cfg_gate_i | input | 4 | Gate code |
| cfg_resync_i | input | 1 | Hold adjacent/software updates to next boundary |
| xfer_o | output | 1 | Shadow-to-active transfer strobe |
| req_o | output | 1 | Interrupt/DMA request pulse |

## Verification
Two kinds of collision are provoked on purpose. In the first, the arming source (DMA complete or an external edge) lands in the same cycle as a consuming event or a software strobe. A single strobe must come out, and the flag must end clear, so a later event stays silent. In the second, a counter boundary meets a fresh master or software update while an earlier one is already held under resync. Both are driven by directed sequences and then by long random runs. A bench model predicts the strobe every cycle, and each expected value is compared with the port one cycle after the stimulus.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  localparam int unsigned GATE_W = 4;
  localparam int unsigned EXT_NOW_BASE = 3;

  typedef enum logic [2:0] {
    G_FREE,
    G_DMA_NOW,
    G_DMA_ARM,
    G_EXT_NOW,
    G_EXT_ARM,
    G_RESV
  } gclass_e;

  function automatic gclass_e gate_class(input logic [GATE_W-1:0] g, input int unsigned n_ext);
    int unsigned gi;
    gi = 32'(g);
    if (gi == 0)                                 return G_FREE;
    else if (gi == 1)                            return G_DMA_NOW;
    else if (gi == 2)                            return G_DMA_ARM;
    else if (gi < EXT_NOW_BASE + n_ext)          return G_EXT_NOW;
    else if (gi < EXT_NOW_BASE + 2 * n_ext)      return G_EXT_ARM;
    else                                         return G_RESV;
  endfunction

endpackage

// File: rtl/xfer_edge_det.sv
module xfer_edge_det #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);

  logic [W-1:0] prev_q;
  logic [W-1:0] prev_n;

  always_comb begin
    prev_n = lvl_i;
    rise_o = lvl_i & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_n;
  end

endmodule

// File: rtl/xfer_resync.sv
module xfer_resync (
  input  logic clk,
  input  logic rst_n,
  input  logic adj_raw_i,
  input  logic sw_i,
  input  logic boundary_i,
  input  logic free_mode_i,
  input  logic resync_i,
  input  logic xfer_i,
  output logic adj_eff_o,
  output logic sw_eff_o,
  output logic release_o
);

  logic hold_q;
  logic hold_n;
  logic defer_act;
  logic defer_now;

  always_comb begin
    defer_act = free_mode_i & resync_i;
    defer_now = defer_act & (adj_raw_i | sw_i);
    adj_eff_o = adj_raw_i & ~defer_act;
    sw_eff_o  = sw_i & ~defer_act;
    release_o = free_mode_i & boundary_i & (hold_q | defer_now);
    if (xfer_i)         hold_n = 1'b0;
    else if (defer_now) hold_n = 1'b1;
    else                hold_n = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_n;
  end

  // R9: a held update is always released at a boundary in the free code
  p_hold_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && boundary_i && free_mode_i) |=> !hold_q);

endmodule

// File: rtl/xfer_gate.sv
module xfer_gate
  import xfer_pkg::*;
#(
  parameter int unsigned N_EXT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GATE_W-1:0] gate_i,
  input  logic              normal_evt_i,
  input  logic              release_i,
  input  logic              sw_i,
  input  logic              dma_i,
  input  logic [N_EXT-1:0]  ext_rise_i,
  output logic              xfer_n_o
);

  localparam int unsigned EXT_ARM_BASE = EXT_NOW_BASE + N_EXT;

  gclass_e          cls;
  logic [N_EXT-1:0] now_sel;
  logic [N_EXT-1:0] arm_sel;
  logic             armed_q;
  logic             armed_n;
  logic             arm;
  logic             fire;

  for (genvar k = 0; k < N_EXT; k++) begin : g_ext
    assign now_sel[k] = (gate_i == GATE_W'(EXT_NOW_BASE + k)) & ext_rise_i[k];
    assign arm_sel[k] = (gate_i == GATE_W'(EXT_ARM_BASE + k)) & ext_rise_i[k];
  end

  always_comb begin
    cls  = gate_class(gate_i, N_EXT);
    fire = sw_i;
    arm  = 1'b0;
    case (cls)
      G_FREE:    fire = fire | normal_evt_i | release_i;
      G_DMA_NOW: fire = fire | dma_i;
      G_DMA_ARM: begin
        fire = fire | (armed_q & normal_evt_i);
        arm  = dma_i;
      end
      G_EXT_NOW: fire = fire | (|now_sel);
      G_EXT_ARM: begin
        fire = fire | (armed_q & normal_evt_i);
        arm  = |arm_sel;
      end
      default:   fire = sw_i;
    endcase
    if (fire)     armed_n = 1'b0;
    else if (arm) armed_n = 1'b1;
    else          armed_n = armed_q;
    xfer_n_o = fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_n;
  end

  // R5/R7: an armed flag is consumed by the first enabled normal event
  p_armed_consumed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && normal_evt_i && (cls == G_DMA_ARM || cls == G_EXT_ARM)) |=> !armed_q);

  // R1: the software strobe leaves no armed flag behind
  p_sw_clears_arm_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sw_i |=> !armed_q);

endmodule

// File: rtl/preload_xfer_ctrl.sv
module preload_xfer_ctrl
  import xfer_pkg::*;
#(
  parameter int unsigned N_SIB = 5,
  parameter int unsigned N_EXT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctr_reset_i,
  input  logic              ctr_roll_i,
  input  logic              rep_zero_i,
  input  logic              continuous_i,
  input  logic              sw_upd_i,
  input  logic              master_upd_i,
  input  logic [N_SIB-1:0]  sib_upd_i,
  input  logic              dma_done_i,
  input  logic [N_EXT-1:0]  ext_en_i,
  input  logic              cfg_rep_en_i,
  input  logic              cfg_rst_en_i,
  input  logic              cfg_master_en_i,
  input  logic [N_SIB-1:0]  cfg_sib_en_i,
  input  logic [GATE_W-1:0] cfg_gate_i,
  input  logic              cfg_resync_i,
  output logic              xfer_o,
  output logic              req_o
);

  localparam int unsigned RESV_FIRST = EXT_NOW_BASE + 2 * N_EXT;

  logic [N_EXT-1:0] ext_rise;
  logic adj_raw, adj_eff, sw_eff, release_w;
  logic boundary, free_mode;
  logic rep_evt, rst_evt, normal_evt;
  logic xfer_n;
  logic xfer_q, req_q;
  logic xfer_d, req_d;

  always_comb begin
    adj_raw   = (cfg_master_en_i & master_upd_i) | (|(cfg_sib_en_i & sib_upd_i));
    boundary  = ctr_reset_i | ctr_roll_i;
    free_mode = (cfg_gate_i == '0);
    rep_evt   = cfg_rep_en_i & ctr_roll_i & rep_zero_i;
    rst_evt   = cfg_rst_en_i & (ctr_reset_i | (ctr_roll_i & continuous_i));
    normal_evt = rep_evt | rst_evt | adj_eff;
  end

  xfer_edge_det #(.W(N_EXT)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (ext_en_i),
    .rise_o (ext_rise)
  );

  xfer_resync u_resync (
    .clk         (clk),
    .rst_n       (rst_n),
    .adj_raw_i   (adj_raw),
    .sw_i        (sw_upd_i),
    .boundary_i  (boundary),
    .free_mode_i (free_mode),
    .resync_i    (cfg_resync_i),
    .xfer_i      (xfer_n),
    .adj_eff_o   (adj_eff),
    .sw_eff_o    (sw_eff),
    .release_o   (release_w)
  );

  xfer_gate #(.N_EXT(N_EXT)) u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .gate_i       (cfg_gate_i),
    .normal_evt_i (normal_evt),
    .release_i    (release_w),
    .sw_i         (sw_eff),
    .dma_i        (dma_done_i),
    .ext_rise_i   (ext_rise),
    .xfer_n_o     (xfer_n)
  );

  always_comb begin
    xfer_d = xfer_n;
    req_d  = xfer_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      xfer_q <= xfer_d;
      req_q  <= req_d;
    end
  end

  assign xfer_o = xfer_q;
  assign req_o  = req_q;

  // R1: software strobe transfers unless deferred by resync in code 0
  p_sw_forces_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_upd_i && !(cfg_gate_i == '0 && cfg_resync_i)) |=> xfer_o);

  // R4: DMA completion transfers directly in code 1
  p_dma_direct_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_gate_i == GATE_W'(1) && dma_done_i) |=> xfer_o);

  // R8: reserved codes block every hardware source
  p_reserved_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cfg_gate_i) >= RESV_FIRST && !sw_upd_i) |=> !xfer_o);

  // R9: nothing transfers between boundaries under resync in code 0
  p_resync_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_gate_i == '0 && cfg_resync_i && !ctr_reset_i && !ctr_roll_i) |=> !xfer_o);

  // R11: request follows each transfer by one cycle and only then
  p_req_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_o |=> req_o);
  p_req_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> $past(xfer_o));

endmodule

// File: tb/preload_xfer_ctrl_bench.sv
module preload_xfer_ctrl_bench;

  localparam int unsigned N_SIB = 5;
  localparam int unsigned N_EXT = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic ctr_reset_i, ctr_roll_i, rep_zero_i, continuous_i;
  logic sw_upd_i, master_upd_i, dma_done_i;
  logic [N_SIB-1:0] sib_upd_i, cfg_sib_en_i;
  logic [N_EXT-1:0] ext_en_i;
  logic cfg_rep_en_i, cfg_rst_en_i, cfg_master_en_i, cfg_resync_i;
  logic [3:0] cfg_gate_i;
  logic xfer_o, req_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit m_hold, m_armed;
  bit [N_EXT-1:0] m_prev;
  bit prev_exp;

  always #4 clk = ~clk;

  preload_xfer_ctrl #(.N_SIB(N_SIB), .N_EXT(N_EXT)) u_preload_xfer_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ctr_reset_i(ctr_reset_i), .ctr_roll_i(ctr_roll_i), .rep_zero_i(rep_zero_i),
    .continuous_i(continuous_i), .sw_upd_i(sw_upd_i), .master_upd_i(master_upd_i),
    .sib_upd_i(sib_upd_i), .dma_done_i(dma_done_i), .ext_en_i(ext_en_i),
    .cfg_rep_en_i(cfg_rep_en_i), .cfg_rst_en_i(cfg_rst_en_i),
    .cfg_master_en_i(cfg_master_en_i), .cfg_sib_en_i(cfg_sib_en_i),
    .cfg_gate_i(cfg_gate_i), .cfg_resync_i(cfg_resync_i),
    .xfer_o(xfer_o), .req_o(req_o)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic string mtag(input logic [3:0] g);
    if (g == 0) return "R2";
    if (g == 1) return "R4";
    if (g == 2) return "R5";
    if (g <= 5) return "R6";
    if (g <= 8) return "R7";
    return "R8";
  endfunction

  // model: returns {xfer, hold_next, armed_next}
  function automatic bit [2:0] model();
    bit free, rs, adj, bnd, defer, rel, adj_e, sw_e, nev, x, arm;
    bit [N_EXT-1:0] rise;
    free  = (cfg_gate_i == 0);
    rs    = free & cfg_resync_i;
    adj   = (cfg_master_en_i & master_upd_i) | (|(cfg_sib_en_i & sib_upd_i));
    rise  = ext_en_i & ~m_prev;
    bnd   = ctr_reset_i | ctr_roll_i;
    defer = rs & (adj | sw_upd_i);
    rel   = free & bnd & (m_hold | defer);
    adj_e = adj & ~rs;
    sw_e  = sw_upd_i & ~rs;
    nev   = (cfg_rep_en_i & ctr_roll_i & rep_zero_i)
          | (cfg_rst_en_i & (ctr_reset_i | (ctr_roll_i & continuous_i))) | adj_e;
    arm = 1'b0;
    if (cfg_gate_i == 0)      x = nev | rel | sw_e;
    else if (cfg_gate_i == 1) x = sw_upd_i | dma_done_i;
    else if (cfg_gate_i == 2) begin x = sw_upd_i | (m_armed & nev); arm = dma_done_i; end
    else if (cfg_gate_i <= 5) x = sw_upd_i | rise[cfg_gate_i - 3];
    else if (cfg_gate_i <= 8) begin x = sw_upd_i | (m_armed & nev); arm = rise[cfg_gate_i - 6]; end
    else                      x = sw_upd_i;
    return {x, (x ? 1'b0 : (defer ? 1'b1 : m_hold)), (x ? 1'b0 : (arm ? 1'b1 : m_armed))};
  endfunction

  task automatic step(input string tag);
    bit [2:0] r;
    r = model();
    @(posedge clk);
    m_hold  = r[1];
    m_armed = r[0];
    m_prev  = ext_en_i;
    @(negedge clk);
    chk(xfer_o, r[2], tag);
    chk(req_o, prev_exp, "R11 request pulse");
    prev_exp = r[2];
  endtask

  task automatic strobes_off();
    ctr_reset_i = 0; ctr_roll_i = 0; sw_upd_i = 0; master_upd_i = 0;
    sib_upd_i = '0; dma_done_i = 0;
  endtask

  task automatic cfg(input logic [3:0] g, input logic rs);
    cfg_gate_i = g; cfg_resync_i = rs;
    cfg_rep_en_i = 1; cfg_rst_en_i = 1; cfg_master_en_i = 1; cfg_sib_en_i = '1;
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0;
    strobes_off();
    rep_zero_i = 0; continuous_i = 0; ext_en_i = '0;
    cfg(4'd0, 1'b0);
    cfg_rep_en_i = 0; cfg_rst_en_i = 0;
    m_hold = 0; m_armed = 0; m_prev = '0; prev_exp = 0;
    repeat (3) @(negedge clk);
    chk(xfer_o, 1'b0, "R12 reset xfer");
    chk(req_o, 1'b0, "R12 reset req");
    sw_upd_i = 1;
    @(negedge clk);
    chk(xfer_o, 1'b0, "R12 strobe in reset");
    sw_upd_i = 0;
    rst_n = 1;
    @(negedge clk);

    // R2 repetition update
    cfg(4'd0, 1'b0); cfg_rst_en_i = 0;
    ctr_roll_i = 1; rep_zero_i = 1; step("R2 roll at zero");
    chk(xfer_o, 1'b1, "R2 roll at zero literal");
    rep_zero_i = 0; step("R2 roll not zero");
    chk(xfer_o, 1'b0, "R2 roll not zero literal");
    strobes_off(); step("R11 tail");

    // R3 reset update
    cfg(4'd0, 1'b0); cfg_rep_en_i = 0;
    ctr_reset_i = 1; step("R3 counter reset");
    chk(xfer_o, 1'b1, "R3 counter reset literal");
    ctr_reset_i = 0; ctr_roll_i = 1; continuous_i = 1; step("R3 continuous roll");
    chk(xfer_o, 1'b1, "R3 continuous roll literal");
    continuous_i = 0; step("R3 single-shot roll");
    chk(xfer_o, 1'b0, "R3 single-shot roll literal");
    strobes_off(); step("R11 tail");

    // R4 direct DMA
    cfg(4'd1, 1'b0);
    ctr_reset_i = 1; master_upd_i = 1; step("R4 events ignored");
    chk(xfer_o, 1'b0, "R4 events ignored literal");
    strobes_off(); dma_done_i = 1; step("R4 dma");
    chk(xfer_o, 1'b1, "R4 dma literal");
    strobes_off(); step("R4 idle");

    // R5 armed DMA, arming cycle collides with event
    cfg(4'd2, 1'b0);
    dma_done_i = 1; ctr_reset_i = 1; step("R5 arm cycle");
    chk(xfer_o, 1'b0, "R5 arm cycle literal");
    strobes_off(); ctr_reset_i = 1; step("R5 consume");
    chk(xfer_o, 1'b1, "R5 consume literal");
    step("R5 flag cleared");
    chk(xfer_o, 1'b0, "R5 flag cleared literal");
    strobes_off(); step("R5 idle");

    // R6 direct external, line 1
    cfg(4'd4, 1'b0);
    ext_en_i = 3'b010; step("R6 line1 rise");
    chk(xfer_o, 1'b1, "R6 line1 rise literal");
    step("R6 held high");
    chk(xfer_o, 1'b0, "R6 held high literal");
    ext_en_i = 3'b011; step("R6 other line");
    chk(xfer_o, 1'b0, "R6 other line literal");
    ext_en_i = 3'b000; step("R6 idle");

    // R7 armed external, line 2
    cfg(4'd8, 1'b0);
    ext_en_i = 3'b100; step("R7 arm line2");
    chk(xfer_o, 1'b0, "R7 arm line2 literal");
    ext_en_i = 3'b000; master_upd_i = 1; step("R7 consume");
    chk(xfer_o, 1'b1, "R7 consume literal");
    strobes_off(); step("R7 idle");

    // R1 software clears armed flag; collision of sw with consuming event
    cfg(4'd2, 1'b0);
    dma_done_i = 1; step("R1 arm");
    strobes_off(); sw_upd_i = 1; ctr_reset_i = 1; step("R1 sw with event");
    chk(xfer_o, 1'b1, "R1 sw with event literal");
    strobes_off(); ctr_reset_i = 1; step("R1 armed cleared");
    chk(xfer_o, 1'b0, "R1 armed cleared literal");
    strobes_off(); step("R1 idle");

    // R8 reserved code
    cfg(4'd12, 1'b0);
    dma_done_i = 1; ctr_reset_i = 1; master_upd_i = 1; ext_en_i = 3'b111; step("R8 hw blocked");
    chk(xfer_o, 1'b0, "R8 hw blocked literal");
    strobes_off(); ext_en_i = '0; sw_upd_i = 1; step("R8 sw only");
    chk(xfer_o, 1'b1, "R8 sw only literal");
    strobes_off(); step("R8 idle");

    // R9 resync deferral
    cfg(4'd0, 1'b1); cfg_rep_en_i = 0; cfg_rst_en_i = 0;
    master_upd_i = 1; step("R9 master held");
    chk(xfer_o, 1'b0, "R9 master held literal");
    strobes_off(); step("R9 still held");
    chk(xfer_o, 1'b0, "R9 still held literal");
    ctr_roll_i = 1; master_upd_i = 1; step("R9 release at roll");
    chk(xfer_o, 1'b1, "R9 release at roll literal");
    strobes_off(); sw_upd_i = 1; step("R9 sw held");
    chk(xfer_o, 1'b0, "R9 sw held literal");
    strobes_off(); ctr_reset_i = 1; step("R9 sw released");
    chk(xfer_o, 1'b1, "R9 sw released literal");
    strobes_off(); step("R9 idle");

    // R10 resync ignored outside code 0
    cfg(4'd6, 1'b1);
    ext_en_i = 3'b001; step("R10 arm line0");
    ext_en_i = '0; sib_upd_i = 5'b00100; step("R10 sibling immediate");
    chk(xfer_o, 1'b1, "R10 sibling immediate literal");
    strobes_off(); step("R10 idle");

    // constrained random
    void'($urandom(32'd4242));
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 19) == 0) begin
        cfg_gate_i   = 4'($urandom_range(0, 15));
        cfg_resync_i = 1'($urandom_range(0, 1));
        cfg_rep_en_i = 1'($urandom_range(0, 1));
        cfg_rst_en_i = 1'($urandom_range(0, 1));
        cfg_master_en_i = 1'($urandom_range(0, 1));
        cfg_sib_en_i = 5'($urandom());
      end
      ctr_reset_i  = ($urandom_range(0, 9) == 0);
      ctr_roll_i   = ($urandom_range(0, 7) == 0);
      rep_zero_i   = 1'($urandom_range(0, 1));
      continuous_i = 1'($urandom_range(0, 1));
      sw_upd_i     = ($urandom_range(0, 24) == 0);
      master_upd_i = ($urandom_range(0, 9) == 0);
      sib_upd_i    = ($urandom_range(0, 5) == 0) ? 5'($urandom()) : '0;
      dma_done_i   = ($urandom_range(0, 9) == 0);
      if ($urandom_range(0, 3) == 0) ext_en_i = 3'($urandom());
      step(mtag(cfg_gate_i));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule